// File: doc/BRIEF.md
# Flash Command Sequencer with Block Lockout

This block is a behavioural controller for a byte-wide parallel flash command port, with a small memory array held in registers. It watches host write cycles, recognises the multi-cycle unlock sequences for byte program, sector erase, page erase, chip erase and identification entry and exit, and then runs the selected operation on an internal timer. When the timer expires, the block returns to read mode by itself, without any help from the host. The real program and erase durations are scaled down to parameters, and so are the array depth, the sector size, the page size and the boot block size.

While an operation is busy, reads return a polling byte instead of array data, and every write is dropped. The protected top block can be locked either by an active-low pin or by a software-controlled input. A second active-low pin protects every byte outside that top block. In identification mode, a fixed status address reports the inverted levels of both lock pins, so the host can see why an operation had no effect.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is in read mode, not busy and not in identification mode, and every array byte reads FF hex.
- R2: The write sequence AA@0x5555, 55@0x2AAA, A0@0x5555, then D@A programs byte A to (old value AND D). Unlock addresses are compared on their low ADDR_W bits.
- R3: The write sequence AA@0x5555, 55@0x2AAA, 80@0x5555, AA@0x5555, 55@0x2AAA, then 30@A sets to FF every byte whose address matches A above bit SECT_W. All other bytes keep their values.
- R4: The same six-cycle sequence ending with 50@A sets to FF only the bytes whose address matches A above bit PAGE_W.
- R5: The six-cycle sequence ending with 10@0x5555 sets every unlocked byte of the array to FF.
- R6: While an operation is busy, every read returns a status byte with bits 6:0 at 0. Bit 7 is 0 during an erase, and during a program it is the complement of bit 7 of the programmed data.
- R7: An operation stays busy for exactly PROG_CYC cycles (program), SECT_CYC cycles (sector or page erase) or CHIP_CYC cycles (chip erase), counted from the clock edge that takes the final command write. After that, reads return the updated array.
- R8: Writes made while an operation is busy are ignored. They neither start a sequence nor advance one.
- R9: A write that does not match the expected cycle of a sequence returns the decoder to its idle state, so the whole sequence has to be started again.
- R10: The top 2^BOOT_W bytes are locked when boot_lock_n is low or sw_boot_lock is high. A program or erase then leaves them unchanged, but the operation still runs for its full time.
- R11: When wp_n is low, every byte outside the top block is locked in the same way as in R10.
- R12: The sequence AA@0x5555, 55@0x2AAA, 90@0x5555 enters identification mode. In this mode, address 0 reads MFR_ID, address 1 reads DEV_ID, and address 0x7FFF2 (low ADDR_W bits) reads {4'b0, ~wp_n, ~boot_lock_n, 2'b0}. Every other address reads 00.
- R13: Identification mode is left either by one F0 write to any address while the decoder is idle, or by the sequence AA@0x5555, 55@0x2AAA, F0@0x5555. Reads then return array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address for both reads and writes |
| bus_wdata | input | 8 | Write data or command byte |
| bus_we | input | 1 | Write strobe, one cycle for each bus write |
| bus_rdata | output | 8 | Read data, a combinational function of bus_addr |
| boot_lock_n | input | 1 | Active-low hardware lock for the top block |
| wp_n | input | 1 | Active-low write protect for all bytes outside the top block |
| sw_boot_lock | input | 1 | Software lock request for the top block |

## Verification
The lock level of each operation is sampled when the operation starts. The assertions and the byte-level expectations therefore assume that boot_lock_n, wp_n and sw_boot_lock stay steady while an operation is busy. The bench changes these inputs only between operations, after it has seen the busy window close. The duration check also assumes every cycle parameter is at least 1 and that CHIP_CYC is no shorter than the other two. The bench drives all inputs on the falling clock edge, so every write is a clean single-cycle strobe, and its sweeps cover each address of the small default array.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OPK_PROG = 2'd0,
    OPK_SECT = 2'd1,
    OPK_PAGE = 2'd2,
    OPK_CHIP = 2'd3
  } op_kind_e;

  localparam logic [7:0] CMD_KEY_A  = 8'hAA;
  localparam logic [7:0] CMD_KEY_B  = 8'h55;
  localparam logic [7:0] CMD_SETUP  = 8'h80;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_LEAVE  = 8'hF0;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_SECTOR = 8'h30;
  localparam logic [7:0] CMD_PAGE   = 8'h50;

  // two addresses fall in the same aligned region of 2^shift bytes
  function automatic logic same_region(input logic [31:0] a, input logic [31:0] b,
                                       input int unsigned shift);
    return (a >> shift) == (b >> shift);
  endfunction

  // address lies in the top 2^bw bytes of a 2^aw byte array
  function automatic logic in_top_block(input logic [31:0] a, input int unsigned aw,
                                        input int unsigned bw);
    return (a >> bw) == ((32'd1 << (aw - bw)) - 32'd1);
  endfunction

  function automatic logic byte_locked(input logic [31:0] a, input int unsigned aw,
                                       input int unsigned bw, input logic top_lk,
                                       input logic rest_lk);
    return in_top_block(a, aw, bw) ? top_lk : rest_lk;
  endfunction

  function automatic logic erase_hits(input op_kind_e k, input logic [31:0] a_byte,
                                      input logic [31:0] a_op, input int unsigned sect_w,
                                      input int unsigned page_w);
    case (k)
      OPK_CHIP: return 1'b1;
      OPK_SECT: return same_region(a_byte, a_op, sect_w);
      OPK_PAGE: return same_region(a_byte, a_op, page_w);
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] poll_byte(input op_kind_e k, input logic [7:0] d);
    return (k == OPK_PROG) ? {~d[7], 7'b0} : 8'h00;
  endfunction

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              op_start,
  output op_kind_e          op_kind,
  output logic              id_set,
  output logic              id_clr,
  output logic              idle
);

  localparam logic [ADDR_W-1:0] KEY_ADDR_A = ADDR_W'(32'h5555);
  localparam logic [ADDR_W-1:0] KEY_ADDR_B = ADDR_W'(32'h2AAA);

  typedef enum logic [2:0] {
    DS_IDLE, DS_KEY1, DS_KEY2, DS_PGM, DS_ER0, DS_ER1, DS_ER2
  } dstate_e;

  dstate_e state_q, state_d;

  logic at_a, at_b;
  assign at_a = (wr_addr == KEY_ADDR_A);
  assign at_b = (wr_addr == KEY_ADDR_B);

  always_comb begin
    state_d  = state_q;
    op_start = 1'b0;
    op_kind  = OPK_PROG;
    id_set   = 1'b0;
    id_clr   = 1'b0;
    if (wr_valid) begin
      state_d = DS_IDLE;
      case (state_q)
        DS_IDLE: begin
          if (at_a && wr_data == CMD_KEY_A) state_d = DS_KEY1;
          else if (wr_data == CMD_LEAVE)    id_clr  = 1'b1;
        end
        DS_KEY1: if (at_b && wr_data == CMD_KEY_B) state_d = DS_KEY2;
        DS_KEY2: begin
          if (at_a) begin
            case (wr_data)
              CMD_PROG:  state_d = DS_PGM;
              CMD_SETUP: state_d = DS_ER0;
              CMD_IDENT: id_set  = 1'b1;
              CMD_LEAVE: id_clr  = 1'b1;
              default:   state_d = DS_IDLE;
            endcase
          end
        end
        DS_PGM: begin
          op_start = 1'b1;
          op_kind  = OPK_PROG;
        end
        DS_ER0: if (at_a && wr_data == CMD_KEY_A) state_d = DS_ER1;
        DS_ER1: if (at_b && wr_data == CMD_KEY_B) state_d = DS_ER2;
        DS_ER2: begin
          if (at_a && wr_data == CMD_CHIP) begin
            op_start = 1'b1;
            op_kind  = OPK_CHIP;
          end else if (wr_data == CMD_SECTOR) begin
            op_start = 1'b1;
            op_kind  = OPK_SECT;
          end else if (wr_data == CMD_PAGE) begin
            op_start = 1'b1;
            op_kind  = OPK_PAGE;
          end
        end
        default: state_d = DS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= DS_IDLE;
    else        state_q <= state_d;
  end

  assign idle = (state_q == DS_IDLE);

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  output logic             busy,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= load - 1'b1;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SECT_W = 4,
  parameter int PAGE_W = 3,
  parameter int BOOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  op_kind_e          kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [7:0]        op_data,
  input  logic              top_lk,
  input  logic              rest_lk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  assign rd_data = mem[rd_addr];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    logic lk, hit_prog, hit_erase;
    assign lk        = byte_locked(32'(g), ADDR_W, BOOT_W, top_lk, rest_lk);
    assign hit_prog  = (kind == OPK_PROG) && (32'(op_addr) == 32'(g));
    assign hit_erase = (kind != OPK_PROG) &&
                       erase_hits(kind, 32'(g), 32'(op_addr), SECT_W, PAGE_W);

    always_ff @(posedge clk) begin
      if (!rst_n)                         mem[g] <= 8'hFF;
      else if (commit && !lk && hit_prog)  mem[g] <= mem[g] & op_data;
      else if (commit && !lk && hit_erase) mem[g] <= 8'hFF;
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter int         SECT_W   = 4,
  parameter int         PAGE_W   = 3,
  parameter int         BOOT_W   = 5,
  parameter int         PROG_CYC = 6,
  parameter int         SECT_CYC = 12,
  parameter int         CHIP_CYC = 20,
  parameter logic [7:0] MFR_ID   = 8'hDA,
  parameter logic [7:0] DEV_ID   = 8'h3D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  output logic [7:0]        bus_rdata,
  input  logic              boot_lock_n,
  input  logic              wp_n,
  input  logic              sw_boot_lock
);

  localparam int MAX_PS  = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_CYC = (MAX_PS > CHIP_CYC) ? MAX_PS : CHIP_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(32'h7FFF2);

  // named internal events
  logic       cmd_we, cmd_start, id_set, id_clr, dec_idle;
  op_kind_e   cmd_kind;
  logic       op_busy, op_done;
  op_kind_e   op_kind;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0] op_data;
  logic       top_lk, rest_lk, id_mode;
  logic [CNT_W-1:0] op_dur;
  logic [7:0] arr_rdata;

  assign cmd_we = bus_we && !op_busy;

  flash_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_valid(cmd_we), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .op_start(cmd_start), .op_kind(cmd_kind),
    .id_set(id_set), .id_clr(id_clr), .idle(dec_idle)
  );

  always_comb begin
    case (cmd_kind)
      OPK_PROG: op_dur = CNT_W'(PROG_CYC);
      OPK_CHIP: op_dur = CNT_W'(CHIP_CYC);
      default:  op_dur = CNT_W'(SECT_CYC);
    endcase
  end

  flash_op_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(cmd_start), .load(op_dur),
    .busy(op_busy), .done(op_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_kind <= OPK_PROG;
      op_addr <= '0;
      op_data <= 8'hFF;
      top_lk  <= 1'b0;
      rest_lk <= 1'b0;
    end else if (cmd_start) begin
      op_kind <= cmd_kind;
      op_addr <= bus_addr;
      op_data <= bus_wdata;
      top_lk  <= !boot_lock_n || sw_boot_lock;
      rest_lk <= !wp_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      id_mode <= 1'b0;
    else if (id_set) id_mode <= 1'b1;
    else if (id_clr) id_mode <= 1'b0;
  end

  flash_byte_array #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PAGE_W(PAGE_W), .BOOT_W(BOOT_W)
  ) u_arr (
    .clk(clk), .rst_n(rst_n), .commit(op_done), .kind(op_kind),
    .op_addr(op_addr), .op_data(op_data), .top_lk(top_lk), .rest_lk(rest_lk),
    .rd_addr(bus_addr), .rd_data(arr_rdata)
  );

  always_comb begin
    if (op_busy)                        bus_rdata = poll_byte(op_kind, op_data);
    else if (!id_mode)                  bus_rdata = arr_rdata;
    else if (bus_addr == STATUS_ADDR)   bus_rdata = {4'b0, ~wp_n, ~boot_lock_n, 2'b00};
    else if (bus_addr == ADDR_W'(0))    bus_rdata = MFR_ID;
    else if (bus_addr == ADDR_W'(1))    bus_rdata = DEV_ID;
    else                                bus_rdata = 8'h00;
  end

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int PROG_CYC = 6,
  parameter int SECT_CYC = 12,
  parameter int CHIP_CYC = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_busy,
  input logic              op_done,
  input logic              cmd_start,
  input op_kind_e          op_kind,
  input logic              dec_idle,
  input logic              id_mode,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic              wp_n,
  input logic              boot_lock_n
);

  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(32'h7FFF2);

  logic [31:0] busy_len;
  logic [31:0] exp_len;

  always_ff @(posedge clk) begin
    if (!rst_n)         busy_len <= '0;
    else if (cmd_start) busy_len <= '0;
    else if (op_busy)   busy_len <= busy_len + 1;
  end

  always_comb begin
    case (op_kind)
      OPK_PROG: exp_len = 32'(PROG_CYC);
      OPK_CHIP: exp_len = 32'(CHIP_CYC);
      default:  exp_len = 32'(SECT_CYC);
    endcase
  end

  assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(op_busy) |-> busy_len == exp_len);

  assert_end_by_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(op_busy) |-> $past(op_done));

  assert_erase_poll_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && op_kind != OPK_PROG) |-> bus_rdata == 8'h00);

  assert_poll_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_busy |-> bus_rdata[6:0] == 7'd0);

  assert_busy_decoder_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_busy |-> (dec_idle && !cmd_start));

  assert_id_status_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (id_mode && !op_busy && bus_addr == STATUS_ADDR) |->
      bus_rdata == {4'b0, ~wp_n, ~boot_lock_n, 2'b00});

endmodule

bind flash_cmd_seq flash_seq_chk #(
  .ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .op_busy(op_busy), .op_done(op_done),
  .cmd_start(cmd_start), .op_kind(op_kind), .dec_idle(dec_idle),
  .id_mode(id_mode), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .wp_n(wp_n), .boot_lock_n(boot_lock_n)
);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DEPTH = 256;
  localparam int TOP_BASE = 224;   // top 32 bytes form the protected block
  localparam int T_PROG = 6;
  localparam int T_SECT = 12;
  localparam int T_CHIP = 20;
  localparam int K_PROG = 0, K_SECT = 1, K_PAGE = 2, K_CHIP = 3;
  localparam logic [7:0] A1 = 8'h55, A2 = 8'hAA, ST = 8'hF2;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic bus_we = 0, boot_lock_n = 1, wp_n = 1, sw_boot_lock = 0;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .boot_lock_n(boot_lock_n),
    .wp_n(wp_n), .sw_boot_lock(sw_boot_lock)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd_now(input logic [7:0] a, output logic [7:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_now(a, v);
  endtask

  function automatic bit locked_at(input int i);
    bit top_l = !boot_lock_n || sw_boot_lock;
    return (i >= TOP_BASE) ? top_l : !wp_n;
  endfunction

  function automatic void model_apply(input int k, input int a, input logic [7:0] d);
    for (int i = 0; i < DEPTH; i++) begin
      if (locked_at(i)) continue;
      case (k)
        K_PROG: if (i == a) model[i] = model[i] & d;
        K_SECT: if ((i >> 4) == (a >> 4)) model[i] = 8'hFF;
        K_PAGE: if ((i >> 3) == (a >> 3)) model[i] = 8'hFF;
        default: model[i] = 8'hFF;
      endcase
    end
  endfunction

  task automatic issue(input int k, input logic [7:0] a, input logic [7:0] d);
    wr(A1, 8'hAA); wr(A2, 8'h55);
    if (k == K_PROG) begin
      wr(A1, 8'hA0); wr(a, d);
    end else begin
      wr(A1, 8'h80); wr(A1, 8'hAA); wr(A2, 8'h55);
      case (k)
        K_SECT: wr(a, 8'h30);
        K_PAGE: wr(a, 8'h50);
        default: wr(A1, 8'h10);
      endcase
    end
  endtask

  // full operation with busy-window and duration checks (R6, R7)
  task automatic run_op(input string req, input int k, input logic [7:0] a,
                        input logic [7:0] d);
    int dur;
    logic [7:0] v, poll;
    dur  = (k == K_PROG) ? T_PROG : (k == K_CHIP) ? T_CHIP : T_SECT;
    poll = (k == K_PROG) ? {~d[7], 7'b0} : 8'h00;
    issue(k, a, d);
    rd_now(a, v);
    chk("R6 poll at start", v, poll);
    repeat (dur - 1) @(negedge clk);
    rd_now(a, v);
    chk("R7 still busy at last cycle", v, poll);
    model_apply(k, a, d);
    @(negedge clk);
    rd_now(a, v);
    chk({req, " R7 result after timer"}, v, model[a]);
  endtask

  task automatic chk_array(input string req);
    int bad = 0;
    logic [7:0] v, fa, fe;
    int faddr = -1;
    for (int i = 0; i < DEPTH; i++) begin
      rd(8'(i), v);
      if (v !== model[i]) begin
        bad++;
        if (faddr < 0) begin faddr = i; fa = v; fe = model[i]; end
      end
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s array addr=%0d actual=%02h expected=%02h (mismatches=%0d)",
               req, faddr, fa, fe, bad);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    chk_array("R1 reset erased");

    // R2: program sweep, two passes, bits only clear
    for (int i = 0; i < DEPTH; i++) begin
      issue(K_PROG, 8'(i), 8'(i) ^ 8'h3C);
      repeat (T_PROG) @(negedge clk);
      model_apply(K_PROG, i, 8'(i) ^ 8'h3C);
    end
    chk_array("R2 program pass 1");
    for (int i = 0; i < DEPTH; i++) begin
      issue(K_PROG, 8'(i), 8'hF0 ^ 8'(i * 3));
      repeat (T_PROG) @(negedge clk);
      model_apply(K_PROG, i, 8'hF0 ^ 8'(i * 3));
    end
    chk_array("R2 program pass 2 AND");
    run_op("R2 R6 prog d7=1", K_PROG, 8'h07, 8'h80);
    run_op("R2 R6 prog d7=0", K_PROG, 8'h08, 8'h01);

    // R4 page, R3 sector
    run_op("R4 page erase", K_PAGE, 8'h13, 8'h00);
    chk_array("R4 page only");
    run_op("R3 sector erase", K_SECT, 8'h2B, 8'h00);
    chk_array("R3 sector only");

    // R11 write protect
    wp_n = 0;
    run_op("R11 prog blocked", K_PROG, 8'h40, 8'h00);
    run_op("R11 top block still writable", K_PROG, 8'hE1, 8'h00);
    run_op("R11 sector erase blocked", K_SECT, 8'h48, 8'h00);
    chk_array("R11 protected bytes");
    wp_n = 1;

    // R10 top block lock via software, then pin
    sw_boot_lock = 1;
    run_op("R10 prog sw lock", K_PROG, 8'hE5, 8'h00);
    run_op("R10 R5 chip erase with lock", K_CHIP, 8'h00, 8'h00);
    chk_array("R5 R10 chip erase keeps top");
    sw_boot_lock = 0; boot_lock_n = 0;
    run_op("R10 sector pin lock", K_SECT, 8'hF3, 8'h00);
    chk_array("R10 pin lock");
    boot_lock_n = 1;
    run_op("R10 unlock erase", K_SECT, 8'hF0, 8'h00);
    chk_array("R10 unlocked");

    // R8: writes during a busy chip erase are ignored
    for (int i = 0; i < 8; i++) begin
      issue(K_PROG, 8'(i), 8'h00);
      repeat (T_PROG) @(negedge clk);
      model_apply(K_PROG, i, 8'h00);
    end
    issue(K_CHIP, 8'h00, 8'h00);
    wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, 8'hA0); wr(8'h00, 8'h00);
    repeat (T_CHIP) @(negedge clk);
    model_apply(K_CHIP, 0, 8'h00);
    wr(8'h00, 8'h00);           // would program if the decoder had advanced
    rd_now(8'h00, v);
    chk("R8 busy writes ignored", v, 8'hFF);
    chk_array("R5 R8 chip erase");

    // R9: wrong cycles reset the decoder
    wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, 8'h77); wr(A1, 8'hA0); wr(8'h10, 8'h00);
    rd_now(8'h10, v);
    chk("R9 bad command byte", v, 8'hFF);
    wr(A1, 8'hAA); wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, 8'hA0); wr(8'h11, 8'h00);
    rd_now(8'h11, v);
    chk("R9 bad second cycle", v, 8'hFF);
    wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, 8'h80); wr(A1, 8'hAA); wr(A1, 8'h55);
    wr(8'h20, 8'h30);
    rd_now(8'h20, v);
    chk("R9 bad erase unlock", v, model[8'h20]);
    run_op("R9 recovers", K_PROG, 8'h12, 8'h5A);

    // R12: identification reads over all pin combinations
    for (int c = 0; c < 4; c++) begin
      boot_lock_n = c[0]; wp_n = c[1];
      wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, 8'h90);
      rd(8'h00, v); chk("R12 maker code", v, 8'hDA);
      rd(8'h01, v); chk("R12 device code", v, 8'h3D);
      rd(ST, v);    chk("R12 lock status", v, {4'b0, ~c[1], ~c[0], 2'b00});
      rd(8'h12, v); chk("R12 other address", v, 8'h00);
      if (c[0]) begin
        wr(8'h33, 8'hF0);
      end else begin
        wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, 8'hF0);
      end
      rd(8'h12, v); chk("R13 back to array", v, model[8'h12]);
      rd(ST, v);    chk("R13 status addr is array", v, model[ST]);
    end
    boot_lock_n = 1; wp_n = 1;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule